// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block is the money-counting core of a vending machine. Each clock cycle it can take one coin, signalled by one of three strobes: a 25-cent coin, a 10-cent coin or a 5-cent coin. It keeps the running amount paid as its state, in steps of 5 cents. When a coin brings the amount to the price of 50 cents or more, the block raises a one-cycle vend pulse and reports the overpayment in cents on the same cycle. The stored amount then drops back to zero, ready for the next customer.

Each cycle is handled as an independent event. A cycle with no strobe leaves the amount unchanged. A cycle with more than one strobe is treated as a fault on the coin path and has no effect. The stored amount is also brought out as a port, so the surrounding logic can show it or monitor it.

Top module: `coin_vend_ctrl`

## Requirements
- R1: A synchronous, active-high reset sets total_cents, vend and change_cents to 0 on the clock edge where it is sampled, whatever the coin strobes are doing.
- R2: When exactly one strobe is high on a clock edge and the new sum stays below 50, total_cents after that edge is the old total plus the coin's value: 25 for coin_25, 10 for coin_10 and 5 for coin_5.
- R3: When exactly one strobe is high and old total plus coin value is 50 or more, vend is 1 during the next cycle only, and total_cents is 0 in that same cycle.
- R4: During a vend cycle, change_cents equals the sum minus 50. It is 0 when the sum is exactly 50, and at most 20 (45 plus 25).
- R5: change_cents is 0 in every cycle in which vend is 0.
- R6: A clock edge with no strobe high keeps total_cents unchanged and leaves vend at 0.
- R7: A clock edge with two or three strobes high is ignored: total_cents is unchanged and vend is 0.
- R8: total_cents is always a multiple of 5 and below 50.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| coin_25 | input | 1 | Strobe: a 25-cent coin is inserted this cycle |
| coin_10 | input | 1 | Strobe: a 10-cent coin is inserted this cycle |
| coin_5 | input | 1 | Strobe: a 5-cent coin is inserted this cycle |
| total_cents | output | 7 | Running amount paid, in cents |
| vend | output | 1 | One-cycle pulse when the price is reached |
| change_cents | output | 7 | Overpayment in cents during the vend cycle, otherwise 0 |

## Verification
Several fixed coin orders are applied. Some reach exactly 50 (two 25-cent coins, five 10-cent coins, ten 5-cent coins), which separates a correct ">= 50" compare from a strict ">" compare and checks that the change is zero. Others overshoot by 5, 10, 15 and 20 cents (such as 45 followed by 25), which exposes errors in the change value and wrong widths at the largest sum. Idle cycles placed between coins and cycles with two or three strobes high show whether the amount is held or wrongly changed. A reset in the middle of a purchase while a coin strobe is high shows that reset wins. A long run of mixed strobe patterns is then compared on every clock against a reference model.

// File: rtl/vend_pkg.sv
package vend_pkg;

    // Money is counted in units of this many cents.
    localparam int UNIT_CENTS  = 5;
    // Price in units (50 cents).
    localparam int PRICE_UNITS = 10;
    localparam int N_COINS     = 3;

    // Strobe vector positions.
    typedef enum int {
        COIN_BIG   = 0,
        COIN_MID   = 1,
        COIN_SMALL = 2
    } coin_slot_e;

    // Value of each coin slot, in units.
    function automatic int coin_units(input int slot);
        case (slot)
            COIN_BIG:   coin_units = 5;
            COIN_MID:   coin_units = 2;
            default:    coin_units = 1;
        endcase
    endfunction

endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode #(
    parameter int N  = 3,
    parameter int UW = 4
) (
    input  logic [N-1:0]  strobe_i,
    output logic [UW-1:0] add_units_o,
    output logic          single_o
);
    logic [UW-1:0] masked [N];

    for (genvar g = 0; g < N; g++) begin : g_slot
        localparam logic [UW-1:0] VAL = UW'(vend_pkg::coin_units(g));
        assign masked[g] = strobe_i[g] ? VAL : '0;
    end

    always_comb begin
        add_units_o = '0;
        for (int i = 0; i < N; i++) begin
            add_units_o = add_units_o | masked[i];
        end
        single_o = ($countones(strobe_i) == 1);
    end

endmodule

// File: rtl/vend_step.sv
module vend_step #(
    parameter int UW          = 4,
    parameter int PRICE_UNITS = 10
) (
    input  logic [UW-1:0] total_i,
    input  logic [UW-1:0] add_i,
    input  logic          take_i,
    output logic [UW-1:0] next_o,
    output logic          hit_o,
    output logic [UW-1:0] excess_o
);
    localparam logic [UW-1:0] PRICE = UW'(PRICE_UNITS);

    logic [UW-1:0] sum;

    always_comb begin
        sum      = total_i + (take_i ? add_i : '0);
        hit_o    = (sum >= PRICE);
        excess_o = hit_o ? (sum - PRICE) : '0;
        next_o   = hit_o ? '0 : sum;
    end

endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl #(
    parameter  int UNIT_CENTS  = vend_pkg::UNIT_CENTS,
    parameter  int PRICE_UNITS = vend_pkg::PRICE_UNITS,
    localparam int MAX_UNITS   = PRICE_UNITS - 1 + vend_pkg::coin_units(vend_pkg::COIN_BIG),
    localparam int UW          = $clog2(MAX_UNITS + 1),
    localparam int CW          = $clog2(MAX_UNITS * UNIT_CENTS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          coin_25,
    input  logic          coin_10,
    input  logic          coin_5,
    output logic [CW-1:0] total_cents,
    output logic          vend,
    output logic [CW-1:0] change_cents
);
    localparam int N = vend_pkg::N_COINS;
    localparam logic [CW-1:0] UC = CW'(UNIT_CENTS);

    typedef struct packed {
        logic [UW-1:0] units;
        logic          vend;
        logic [UW-1:0] chg;
    } vend_state_t;

    vend_state_t st_d, st_q;

    logic [N-1:0]  strobe;
    logic [UW-1:0] add_units;
    logic          single;
    logic [UW-1:0] next_units;
    logic          hit;
    logic [UW-1:0] excess;

    always_comb begin
        strobe                        = '0;
        strobe[vend_pkg::COIN_BIG]    = coin_25;
        strobe[vend_pkg::COIN_MID]    = coin_10;
        strobe[vend_pkg::COIN_SMALL]  = coin_5;
    end

    vend_coin_decode #(.N(N), .UW(UW)) i_decode (
        .strobe_i    (strobe),
        .add_units_o (add_units),
        .single_o    (single)
    );

    vend_step #(.UW(UW), .PRICE_UNITS(PRICE_UNITS)) i_step (
        .total_i  (st_q.units),
        .add_i    (add_units),
        .take_i   (single),
        .next_o   (next_units),
        .hit_o    (hit),
        .excess_o (excess)
    );

    always_comb begin
        st_d       = st_q;
        st_d.units = next_units;
        st_d.vend  = hit;
        st_d.chg   = excess;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign total_cents  = CW'(st_q.units) * UC;
    assign vend         = st_q.vend;
    assign change_cents = CW'(st_q.chg) * UC;

endmodule

// File: rtl/vend_chk.sv
module vend_chk #(
    parameter int CW          = 7,
    parameter int PRICE_CENTS = 50
) (
    input logic          clk,
    input logic          rst,
    input logic          coin_25,
    input logic          coin_10,
    input logic          coin_5,
    input logic [CW-1:0] total_cents,
    input logic          vend,
    input logic [CW-1:0] change_cents
);
    logic [7:0] coin_val;
    logic [7:0] sum_now;
    logic [1:0] n_strobe;

    always_comb begin
        n_strobe = 2'(coin_25) + 2'(coin_10) + 2'(coin_5);
        coin_val = coin_25 ? 8'd25 : (coin_10 ? 8'd10 : (coin_5 ? 8'd5 : 8'd0));
        sum_now  = 8'(total_cents) + coin_val;
    end

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (total_cents == '0 && !vend && change_cents == '0));

    a_r2_coin_adds: assert property (@(posedge clk) disable iff (rst)
        (n_strobe == 2'd1 && sum_now < 8'(PRICE_CENTS))
        |=> (8'(total_cents) == $past(sum_now) && !vend));

    a_r3_vend_resets_total: assert property (@(posedge clk) disable iff (rst)
        (n_strobe == 2'd1 && sum_now >= 8'(PRICE_CENTS))
        |=> (vend && total_cents == '0));

    a_r3_vend_single_cycle: assert property (@(posedge clk) disable iff (rst)
        vend |=> !vend);

    a_r4_change_value: assert property (@(posedge clk) disable iff (rst)
        (n_strobe == 2'd1 && sum_now >= 8'(PRICE_CENTS))
        |=> (8'(change_cents) == $past(sum_now) - 8'(PRICE_CENTS)));

    a_r5_change_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !vend |-> (change_cents == '0));

    a_r6_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (n_strobe == 2'd0) |=> ($stable(total_cents) && !vend));

    a_r7_multi_ignored: assert property (@(posedge clk) disable iff (rst)
        (n_strobe > 2'd1) |=> ($stable(total_cents) && !vend));

    a_r8_total_range: assert property (@(posedge clk) disable iff (rst)
        (8'(total_cents) < 8'(PRICE_CENTS)));

endmodule

bind coin_vend_ctrl vend_chk #(.CW(CW), .PRICE_CENTS(PRICE_UNITS * UNIT_CENTS)) i_vend_chk (
    .clk          (clk),
    .rst          (rst),
    .coin_25      (coin_25),
    .coin_10      (coin_10),
    .coin_5       (coin_5),
    .total_cents  (total_cents),
    .vend         (vend),
    .change_cents (change_cents)
);

// File: tb/test_coin_vend_ctrl.sv
module test_coin_vend_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       c25 = 1'b0;
    logic       c10 = 1'b0;
    logic       c5  = 1'b0;
    logic [6:0] total_cents;
    logic       vend;
    logic [6:0] change_cents;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    int m_total = 0;
    int m_vend  = 0;
    int m_chg   = 0;

    always #4 clk = ~clk;

    coin_vend_ctrl i_coin_vend_ctrl (
        .clk          (clk),
        .rst          (rst),
        .coin_25      (c25),
        .coin_10      (c10),
        .coin_5       (c5),
        .total_cents  (total_cents),
        .vend         (vend),
        .change_cents (change_cents)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, int'(total_cents), m_total);
        chk(tag, int'(vend), m_vend);
        chk((m_vend != 0) ? "R4" : "R5", int'(change_cents), m_chg);
        chk("R8", ((total_cents < 7'd50) && (total_cents % 7'd5 == 0)) ? 1 : 0, 1);
    endtask

    // Drive one cycle of strobes, update the reference model, compare after the edge.
    task automatic step(input logic a, input logic b, input logic c);
        int n;
        int add;
        int sum;
        string tag;
        c25 = a; c10 = b; c5 = c;
        n   = int'(a) + int'(b) + int'(c);
        add = 0;
        if (n == 1) add = a ? 25 : (b ? 10 : 5);
        sum = m_total + add;
        if (sum >= 50) begin
            m_vend = 1; m_chg = sum - 50; m_total = 0;
        end else begin
            m_vend = 0; m_chg = 0; m_total = sum;
        end
        if (n > 1)            tag = "R7";
        else if (n == 0)      tag = "R6";
        else if (m_vend != 0) tag = "R3";
        else                  tag = "R2";
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic do_reset(input logic a, input logic b, input logic c);
        rst = 1'b1;
        c25 = a; c10 = b; c5 = c;
        m_total = 0; m_vend = 0; m_chg = 0;
        @(posedge clk);
        @(negedge clk);
        compare_all("R1");
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        do_reset(1'b0, 1'b0, 1'b0);              // R1 plain reset

        step(1, 0, 0); step(1, 0, 0);            // R3 exactly 50, change 0
        step(0, 0, 0);                           // R6
        repeat (5) step(0, 1, 0);                // R2/R3 50 with dimes
        repeat (10) step(0, 0, 1);               // R2/R3 50 with nickels
        step(0, 1, 0); step(1, 0, 0); step(1, 0, 0);   // 60, R4 change 10
        step(1, 0, 0); step(0, 1, 0); step(0, 1, 0);   // 45
        step(0, 0, 0);                           // R6 hold at 45
        step(1, 1, 0); step(0, 1, 1); step(1, 0, 1); step(1, 1, 1); // R7
        step(1, 0, 0);                           // 70, R4 change 20
        step(1, 0, 0); step(0, 0, 1); step(1, 0, 0);   // 55, change 5
        step(1, 0, 0); step(0, 1, 0); step(0, 0, 1); step(1, 0, 0); // 65, change 15
        step(1, 0, 0); step(0, 1, 0);            // 35
        do_reset(1'b1, 1'b0, 1'b0);              // R1 reset wins over coin
        step(0, 0, 1);

        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom_range(0, 9));
            case (r)
                0, 1, 2: step(1, 0, 0);
                3, 4:    step(0, 1, 0);
                5, 6:    step(0, 0, 1);
                7:       step(0, 0, 0);
                8:       step(1, 1, 0);
                default: step(logic'($urandom_range(0, 1)), 1, 1);
            endcase
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule